// File: doc/BRIEF.md
# Masked Status Interrupt Generator

This block turns five status conditions reported by a token-passing network controller core into one interrupt request for the host. Two of the conditions are levels that the core drives continuously: the receiver is inhibited, and the transmitter is available. The other three are one-cycle event pulses that the block latches into sticky flags: a new next-node ID was learned, too many negative acknowledgements were seen, and the reconfiguration timer expired.

The host reaches the block through a small register port. It can write an 8-bit mask, in which each enable bit sits at the same position as its condition in the status vector. It can read back the status vector and the mask, and it can issue clear commands. A read of the next-ID location also clears the new-next-ID flag as a side effect. Masking only gates the output. A hidden condition that is still pending shows again as soon as its mask bit is set.

Top module: `irq_status_gen`

## Requirements
- R1: After reset the mask is 0x00, all sticky flags are 0 and `irqOut` is 0.
- R2: Status and mask share these bit positions: transmitter available bit 0, new next ID bit 2, excessive NAK bit 3, reconfiguration timer bit 4, receiver inhibited bit 7. A status read (`hostAddr` 0) returns the conditions at these positions and 0 in bits 1, 5 and 6.
- R3: `irqOut` is a register that is 1 when any condition ANDed with its mask bit is 1. A mask write, a clear or a sticky set takes effect on `irqOut` two clock edges after the host or event strobe is sampled. A level input change takes effect one edge after it is sampled.
- R4: Mask bits 1, 5 and 6 are stored and read back, but they never affect `irqOut`.
- R5: `rxInhibit` and `txAvail` are levels. Clearing their mask bit hides them, and setting it again restores the interrupt while the level is still 1.
- R6: The sticky flags are set by `newNidPulse`, `excNakPulse` and `reconPulse`. They stay set until their own clear, and masking never clears them.
- R7: A command write (`hostAddr` 1) of 0x1E clears only the reconfiguration flag.
- R8: A command write of 0x2E clears the excessive NAK flag and the reconfiguration flag. No other command value clears the excessive NAK flag, and a command of any other value has no effect.
- R9: A read of `hostAddr` 2 (the next-ID location) clears the new-next-ID flag. A status read at address 0 does not clear it.
- R10: When a set pulse and its clear happen in the same cycle, the flag ends up set.
- R11: A mask write goes to `hostAddr` 0, and the mask reads back at `hostAddr` 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| rxInhibit | input | 1 | Receiver inhibited level |
| txAvail | input | 1 | Transmitter available level |
| newNidPulse | input | 1 | New next ID event pulse |
| excNakPulse | input | 1 | Excessive NAK event pulse |
| reconPulse | input | 1 | Reconfiguration timer event pulse |
| hostAddr | input | 2 | Host register address |
| hostWr | input | 1 | Host write strobe |
| hostRd | input | 1 | Host read strobe |
| hostWdata | input | 8 | Host write data |
| hostRdata | output | 8 | Host read data, combinational |
| irqOut | output | 1 | Registered active-high interrupt |

## Verification
An event pulse or host strobe is captured on the first clock edge. `irqOut` reflects that change on the second edge. A level input shows on `irqOut` after the first edge. Read data is combinational, so it is valid while the read strobe is held. The bench drives every input on the falling edge. After each stimulus it waits the exact number of rising edges that the path needs, then samples on the next falling edge. Checks that something stays unchanged wait one extra edge before they sample.

// File: rtl/irq_status_pkg.sv
package irq_status_pkg;
  parameter int DATA_W = 8;
  parameter int ADDR_W = 2;

  localparam int BIT_TA    = 0;
  localparam int BIT_NID   = 2;
  localparam int BIT_EXC   = 3;
  localparam int BIT_RECON = 4;
  localparam int BIT_RI    = 7;

  localparam logic [DATA_W-1:0] IRQ_BITS =
    DATA_W'((1 << BIT_TA) | (1 << BIT_NID) | (1 << BIT_EXC) | (1 << BIT_RECON) | (1 << BIT_RI));

  localparam logic [ADDR_W-1:0] ADDR_STAT = ADDR_W'(0);
  localparam logic [ADDR_W-1:0] ADDR_CMD  = ADDR_W'(1);
  localparam logic [ADDR_W-1:0] ADDR_NID  = ADDR_W'(2);

  localparam logic [DATA_W-1:0] CMD_CLR   = DATA_W'(8'h1E);
  localparam logic [DATA_W-1:0] CMD_PORCL = DATA_W'(8'h2E);

  typedef struct packed {
    logic maskWr;
    logic clrRecon;
    logic clrExc;
    logic clrNid;
    logic selStatus;
    logic selMask;
  } irqStrobe_t;
endpackage

// File: rtl/irq_status_ctrl.sv
module irq_status_ctrl
  import irq_status_pkg::*;
(
  input  logic [ADDR_W-1:0] hostAddr,
  input  logic              hostWr,
  input  logic              hostRd,
  input  logic [DATA_W-1:0] hostWdata,
  output irqStrobe_t        stb
);
  logic cmdWr;

  always_comb begin
    cmdWr         = hostWr && (hostAddr == ADDR_CMD);
    stb.maskWr    = hostWr && (hostAddr == ADDR_STAT);
    stb.clrRecon  = cmdWr && ((hostWdata == CMD_CLR) || (hostWdata == CMD_PORCL));
    stb.clrExc    = cmdWr && (hostWdata == CMD_PORCL);
    stb.clrNid    = hostRd && (hostAddr == ADDR_NID);
    stb.selStatus = (hostAddr == ADDR_STAT);
    stb.selMask   = (hostAddr == ADDR_CMD);
  end
endmodule

// File: rtl/irq_status_dp.sv
module irq_status_dp
  import irq_status_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  irqStrobe_t        stb,
  input  logic              rxInhibit,
  input  logic              txAvail,
  input  logic              newNidPulse,
  input  logic              excNakPulse,
  input  logic              reconPulse,
  input  logic [DATA_W-1:0] hostWdata,
  output logic [DATA_W-1:0] hostRdata,
  output logic [DATA_W-1:0] maskQ,
  output logic              nidQ,
  output logic              excQ,
  output logic              reconQ,
  output logic              irqQ
);
  logic [DATA_W-1:0] statusVec;

  always_comb begin
    statusVec            = '0;
    statusVec[BIT_TA]    = txAvail;
    statusVec[BIT_NID]   = nidQ;
    statusVec[BIT_EXC]   = excQ;
    statusVec[BIT_RECON] = reconQ;
    statusVec[BIT_RI]    = rxInhibit;
  end

  always_comb begin
    if (stb.selStatus)    hostRdata = statusVec;
    else if (stb.selMask) hostRdata = maskQ;
    else                  hostRdata = '0;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      maskQ  <= '0;
      nidQ   <= 1'b0;
      excQ   <= 1'b0;
      reconQ <= 1'b0;
      irqQ   <= 1'b0;
    end else begin
      if (stb.maskWr) maskQ <= hostWdata;
      if (newNidPulse)      nidQ <= 1'b1;
      else if (stb.clrNid)  nidQ <= 1'b0;
      if (excNakPulse)      excQ <= 1'b1;
      else if (stb.clrExc)  excQ <= 1'b0;
      if (reconPulse)         reconQ <= 1'b1;
      else if (stb.clrRecon)  reconQ <= 1'b0;
      irqQ <= |(statusVec & maskQ & IRQ_BITS);
    end
  end
endmodule

// File: rtl/irq_status_gen.sv
module irq_status_gen
  import irq_status_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              rxInhibit,
  input  logic              txAvail,
  input  logic              newNidPulse,
  input  logic              excNakPulse,
  input  logic              reconPulse,
  input  logic [ADDR_W-1:0] hostAddr,
  input  logic              hostWr,
  input  logic              hostRd,
  input  logic [DATA_W-1:0] hostWdata,
  output logic [DATA_W-1:0] hostRdata,
  output logic              irqOut
);
  irqStrobe_t        stb;
  logic [DATA_W-1:0] maskQ;
  logic              nidQ, excQ, reconQ;

  irq_status_ctrl u_ctrl (
    .hostAddr (hostAddr),
    .hostWr   (hostWr),
    .hostRd   (hostRd),
    .hostWdata(hostWdata),
    .stb      (stb)
  );

  irq_status_dp u_dp (
    .clk        (clk),
    .rstN       (rstN),
    .stb        (stb),
    .rxInhibit  (rxInhibit),
    .txAvail    (txAvail),
    .newNidPulse(newNidPulse),
    .excNakPulse(excNakPulse),
    .reconPulse (reconPulse),
    .hostWdata  (hostWdata),
    .hostRdata  (hostRdata),
    .maskQ      (maskQ),
    .nidQ       (nidQ),
    .excQ       (excQ),
    .reconQ     (reconQ),
    .irqQ       (irqOut)
  );
endmodule

// File: rtl/irq_status_chk.sv
module irq_status_chk
  import irq_status_pkg::*;
(
  input logic              clk,
  input logic              rstN,
  input irqStrobe_t        stb,
  input logic [DATA_W-1:0] maskQ,
  input logic              nidQ,
  input logic              excQ,
  input logic              reconQ,
  input logic              newNidPulse,
  input logic              excNakPulse,
  input logic              reconPulse,
  input logic              irqOut
);
  a_r10_exc_set_wins: assert property (@(posedge clk) disable iff (!rstN)
    excNakPulse |=> excQ);
  a_r10_nid_set_wins: assert property (@(posedge clk) disable iff (!rstN)
    newNidPulse |=> nidQ);
  a_r8_exc_holds: assert property (@(posedge clk) disable iff (!rstN)
    (excQ && !stb.clrExc) |=> excQ);
  a_r9_nid_clear: assert property (@(posedge clk) disable iff (!rstN)
    (stb.clrNid && !newNidPulse) |=> !nidQ);
  a_r7_recon_clear: assert property (@(posedge clk) disable iff (!rstN)
    (stb.clrRecon && !reconPulse) |=> !reconQ);
  a_r4_unused_mask: assert property (@(posedge clk) disable iff (!rstN)
    ((maskQ & IRQ_BITS) == '0) |=> !irqOut);
  a_r6_recon_holds: assert property (@(posedge clk) disable iff (!rstN)
    (reconQ && !stb.clrRecon) |=> reconQ);
endmodule

bind irq_status_gen irq_status_chk u_chk (
  .clk        (clk),
  .rstN       (rstN),
  .stb        (stb),
  .maskQ      (maskQ),
  .nidQ       (nidQ),
  .excQ       (excQ),
  .reconQ     (reconQ),
  .newNidPulse(newNidPulse),
  .excNakPulse(excNakPulse),
  .reconPulse (reconPulse),
  .irqOut     (irqOut)
);

// File: tb/test_irq_status_gen.sv
module test_irq_status_gen;
  timeunit 1ns;
  timeprecision 1ps;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       rxInhibit = 1'b0, txAvail = 1'b0;
  logic       newNidPulse = 1'b0, excNakPulse = 1'b0, reconPulse = 1'b0;
  logic [1:0] hostAddr = '0;
  logic       hostWr = 1'b0, hostRd = 1'b0;
  logic [7:0] hostWdata = '0;
  logic [7:0] hostRdata;
  logic       irqOut;
  int         nChecks = 0, nFails = 0;

  always #2 clk = ~clk;

  irq_status_gen i_irq_status_gen (
    .clk, .rstN, .rxInhibit, .txAvail, .newNidPulse, .excNakPulse, .reconPulse,
    .hostAddr, .hostWr, .hostRd, .hostWdata, .hostRdata, .irqOut
  );

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic tick(input int n);
    repeat (n) @(posedge clk);
    @(negedge clk);
  endtask

  task automatic hostWrite(input logic [1:0] a, input logic [7:0] d);
    hostAddr = a; hostWdata = d; hostWr = 1'b1;
    @(negedge clk);
    hostWr = 1'b0;
  endtask

  task automatic hostRead(input logic [1:0] a, output logic [7:0] d);
    hostAddr = a; hostRd = 1'b1;
    #0.5 d = hostRdata;
    @(negedge clk);
    hostRd = 1'b0;
  endtask

  task automatic pulseNid();   newNidPulse = 1'b1; @(negedge clk); newNidPulse = 1'b0; endtask
  task automatic pulseExc();   excNakPulse = 1'b1; @(negedge clk); excNakPulse = 1'b0; endtask
  task automatic pulseRecon(); reconPulse  = 1'b1; @(negedge clk); reconPulse  = 1'b0; endtask

  task automatic t_reset();
    logic [7:0] d;
    chk("R1 irq", {7'b0, irqOut}, 8'h00);
    hostRead(2'd1, d); chk("R1 mask", d, 8'h00);
    hostRead(2'd0, d); chk("R1 status", d, 8'h00);
  endtask

  task automatic t_positions();
    logic [7:0] d;
    pulseNid(); hostRead(2'd0, d); chk("R2 nid bit", d, 8'h04);
    pulseExc(); hostRead(2'd0, d); chk("R2 exc bit", d, 8'h0C);
    pulseRecon(); hostRead(2'd0, d); chk("R2 recon bit", d, 8'h1C);
    txAvail = 1'b1; rxInhibit = 1'b1;
    hostRead(2'd0, d); chk("R2 all bits", d, 8'h9D);
    hostWrite(2'd0, 8'h62); hostRead(2'd1, d); chk("R11 mask readback", d, 8'h62);
    tick(2); chk("R4 unused mask bits", {7'b0, irqOut}, 8'h00);
    hostWrite(2'd1, 8'h2E); hostRead(2'd2, d);
    txAvail = 1'b0; rxInhibit = 1'b0;
    hostRead(2'd0, d); chk("R8 R9 all flags clear", d, 8'h00);
  endtask

  task automatic t_levels();
    hostWrite(2'd0, 8'h80);
    rxInhibit = 1'b1; tick(1); chk("R5 ri raises irq", {7'b0, irqOut}, 8'h01);
    hostWrite(2'd0, 8'h00); tick(1); chk("R5 ri masked", {7'b0, irqOut}, 8'h00);
    hostWrite(2'd0, 8'h80); tick(1); chk("R5 ri reappears", {7'b0, irqOut}, 8'h01);
    rxInhibit = 1'b0; tick(1); chk("R5 ri level drop", {7'b0, irqOut}, 8'h00);
    hostWrite(2'd0, 8'h01); txAvail = 1'b1; tick(1);
    chk("R3 ta raises irq", {7'b0, irqOut}, 8'h01);
    txAvail = 1'b0; tick(1);
  endtask

  task automatic t_excnak();
    logic [7:0] d;
    hostWrite(2'd0, 8'h00);
    pulseExc(); tick(2); chk("R6 masked exc no irq", {7'b0, irqOut}, 8'h00);
    hostWrite(2'd0, 8'h08); tick(1); chk("R6 exc reappears", {7'b0, irqOut}, 8'h01);
    hostWrite(2'd1, 8'h1E); tick(1); chk("R7 clr keeps exc", {7'b0, irqOut}, 8'h01);
    hostWrite(2'd1, 8'h55); tick(1); chk("R8 other cmd keeps exc", {7'b0, irqOut}, 8'h01);
    hostWrite(2'd1, 8'h2E); tick(1); chk("R8 por clr clears exc", {7'b0, irqOut}, 8'h00);
    hostRead(2'd0, d); chk("R8 exc flag", d & 8'h08, 8'h00);
  endtask

  task automatic t_recon();
    logic [7:0] d;
    hostWrite(2'd0, 8'h10);
    pulseRecon(); tick(1); chk("R3 recon irq", {7'b0, irqOut}, 8'h01);
    hostWrite(2'd1, 8'h55); tick(1); chk("R8 other cmd keeps recon", {7'b0, irqOut}, 8'h01);
    hostWrite(2'd1, 8'h1E); tick(1); chk("R7 clr clears recon", {7'b0, irqOut}, 8'h00);
    reconPulse = 1'b1; hostWrite(2'd1, 8'h1E); reconPulse = 1'b0;
    hostRead(2'd0, d); chk("R10 recon set wins", d & 8'h10, 8'h10);
    hostWrite(2'd1, 8'h1E); tick(1);
  endtask

  task automatic t_nid();
    logic [7:0] d;
    hostWrite(2'd0, 8'h04);
    pulseNid(); tick(1); chk("R6 nid irq", {7'b0, irqOut}, 8'h01);
    hostRead(2'd0, d); tick(1); chk("R9 status read keeps nid", {7'b0, irqOut}, 8'h01);
    hostRead(2'd2, d); tick(1); chk("R9 nid read clears", {7'b0, irqOut}, 8'h00);
    newNidPulse = 1'b1; hostRead(2'd2, d); newNidPulse = 1'b0;
    hostRead(2'd0, d); chk("R10 nid set wins", d & 8'h04, 8'h04);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    nChecks++; nFails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("  == %0d vectors applied, %0d miscompares ==", nChecks, nFails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    t_reset();
    t_positions();
    t_levels();
    t_excnak();
    t_recon();
    t_nid();
    $display("  == %0d vectors applied, %0d miscompares ==", nChecks, nFails);
    $finish;
  end
endmodule